// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible configuration and status store of a colour LCD controller. A host reaches it through a simple APB-style bus with 32-bit word accesses: a setup cycle with `psel` high, then an access cycle with `psel` and `penable` both high. Writes land on the clock edge that closes the access cycle, and read data and the error flag are driven combinationally during the access cycle. The bank keeps four timing words, the base addresses of the upper and lower panel frames, a control word, an interrupt mask and a raw interrupt status. Interrupt event pulses arrive from the rest of the controller on `irq_evt`.

The bank drives the panel geometry and control state straight to the display engine. Width and height come from fixed formulas on fields of the first two timing words. The enable needs both an enable bit and a power bit. The pixel-depth code and three ordering flags are passed through as they are. A one-cycle pulse flags every change of geometry. The `VARIANT` parameter picks one of two register layouts. Each layout has its own identification bytes, and in the extended layout the mask and control words trade places.

Top module: `lcd_regbank`

## Requirements
- R1: The control word keeps bits 11:0 and reads them back, with bits 31:12 as zero. Its fields are: bit 0 enable, bits 3:1 pixel-depth code (`depth_code`), bit 8 colour-swap (`bgr_swap`), bit 9 big-endian byte order (`be_bytes`), bit 10 big-endian pixel order within a byte (`be_pixels`), and bit 11 power.
- R2: `disp_en` is 1 only when control bit 0 and control bit 11 are both 1.
- R3: A write to word 0 sets `panel_width` to ((data AND 0xFC) + 4) * 4.
- R4: A write to word 1 sets `panel_height` to (data AND 0x3FF) + 1.
- R5: Words 0 to 3 are timing words 0 to 3, word 4 is the upper panel base and word 5 is the lower panel base. All six are full 32-bit words that read back as written.
- R6: With VARIANT=0, word 6 is the interrupt mask and word 7 is the control word. With VARIANT=1 the two are swapped. The mask keeps NUM_IRQ bits and reads back with the upper bits as zero.
- R7: Word 8 reads the raw status. Each `irq_evt` bit sampled high sets its status bit, and a set in the same cycle as a clear wins.
- R8: A write to word 10 clears every raw status bit whose data bit is 1 and leaves the other bits unchanged.
- R9: Word 9 reads raw status AND mask, and `irq` is the OR of those masked bits.
- R10: Byte offsets 0xFE0 to 0xFFF (words 1016 to 1023) read one ID byte each, indexed by word bits 2:0. The bytes are 10 11 04 00 0D F0 05 B1 for VARIANT=0 and 11 11 24 00 0D F0 05 B1 for VARIANT=1.
- R11: Any other word (13 to 1015) raises `pslverr` during the access cycle and reads as zero. A write to such a word changes no register.
- R12: Words 11 and 12 read back the upper and lower panel base respectively.
- R13: `resize_pulse` is high for exactly one cycle after a width or height write that changes the value. A write that leaves the value unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address, bits 1:0 ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pslverr | output | 1 | Unmapped-offset error flag, high during the access cycle |
| irq_evt | input | NUM_IRQ | Interrupt event pulses |
| irq | output | 1 | Interrupt request |
| panel_width | output | DIM_W | Panel width in pixels |
| panel_height | output | DIM_W | Panel height in lines |
| resize_pulse | output | 1 | One-cycle pulse on a geometry change |
| disp_en | output | 1 | Display enabled |
| depth_code | output | 3 | Pixel-depth code |
| bgr_swap | output | 1 | Colour component swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within a byte |

## Verification
Read data and the error flag are combinational, so the bench samples them one time unit after it raises `penable`, inside the access cycle. A register write takes effect on the edge that closes the access cycle. The bench therefore checks the derived outputs, `disp_en`, the width, the height and the status, at the next falling edge, which is the first point at which they can show the new value. The same falling edge is where `resize_pulse` must be high, and the bench confirms one cycle later that the pulse has gone low. An event pulse held across one rising edge must appear in the raw status at the falling edge that follows.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = ADDR_W - 2;
  localparam int NWORDS = 13;

  localparam int WI_TIM0  = 0;
  localparam int WI_TIM1  = 1;
  localparam int WI_UBASE = 4;
  localparam int WI_LBASE = 5;
  localparam int WI_MASK  = 6;
  localparam int WI_CTRL  = 7;
  localparam int WI_RAW   = 8;
  localparam int WI_MSTAT = 9;
  localparam int WI_CLR   = 10;
  localparam int WI_UCUR  = 11;
  localparam int WI_LCUR  = 12;

  localparam int CTRL_W   = 12;
  localparam int CB_EN    = 0;
  localparam int CB_DEPTH = 1;
  localparam int CB_BGR   = 8;
  localparam int CB_BEB   = 9;
  localparam int CB_BEP   = 10;
  localparam int CB_PWR   = 11;

  function automatic logic [7:0] id_byte(input int variant, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = (variant != 0) ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = (variant != 0) ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcd_reg_decode.sv
module lcd_reg_decode
  import lcd_regbank_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [WORD_W-1:0] word,
  output logic [NWORDS-1:0] hit,
  output logic              id_hit,
  output logic [2:0]        id_idx,
  output logic              miss
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_hit
    localparam int PHYS = (VARIANT != 0 && i == WI_MASK) ? WI_CTRL :
                          (VARIANT != 0 && i == WI_CTRL) ? WI_MASK : i;
    assign hit[i] = (word == WORD_W'(PHYS));
  end

  assign id_hit = (word[WORD_W-1:3] == '1);
  assign id_idx = word[2:0];
  assign miss   = !(|hit) && !id_hit;
endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] evt,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_bits,
  input  logic               mask_we,
  input  logic [NUM_IRQ-1:0] mask_bits,
  output logic [NUM_IRQ-1:0] raw,
  output logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] masked,
  output logic               irq
);
  logic [NUM_IRQ-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~clr_eff) | evt;
      if (mask_we) mask <= mask_bits;
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/lcd_panel_geom.sv
module lcd_panel_geom #(
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t0_we,
  input  logic [7:0]       t0_data,
  input  logic             t1_we,
  input  logic [9:0]       t1_data,
  output logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] height,
  output logic             resize
);
  logic [DIM_W-1:0] w_new, h_new;
  assign w_new = DIM_W'((32'(t0_data[7:2]) + 32'd1) * 32'd16);
  assign h_new = DIM_W'(32'(t1_data) + 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width  <= '0;
      height <= '0;
      resize <= 1'b0;
    end else begin
      if (t0_we) width  <= w_new;
      if (t1_we) height <= h_new;
      resize <= (t0_we && (w_new != width)) || (t1_we && (h_new != height));
    end
  end
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int NUM_IRQ = 4,
  parameter int DIM_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [11:0]        paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pslverr,
  input  logic [NUM_IRQ-1:0] irq_evt,
  output logic               irq,
  output logic [DIM_W-1:0]   panel_width,
  output logic [DIM_W-1:0]   panel_height,
  output logic               resize_pulse,
  output logic               disp_en,
  output logic [2:0]         depth_code,
  output logic               bgr_swap,
  output logic               be_bytes,
  output logic               be_pixels
);
  localparam int NUM_TIM = 4;

  logic              acc, wr;
  logic [NWORDS-1:0] hit;
  logic              id_hit, miss;
  logic [2:0]        id_idx;
  logic [31:0]       tim [NUM_TIM];
  logic [31:0]       ubase, lbase;
  logic [CTRL_W-1:0] ctrl;
  logic [NUM_IRQ-1:0] raw, mask, masked;
  logic [31:0]       rdat;

  assign acc = psel & penable;
  assign wr  = acc & pwrite;

  lcd_reg_decode #(.VARIANT(VARIANT)) u_dec (
    .word(paddr[11:2]), .hit(hit), .id_hit(id_hit), .id_idx(id_idx), .miss(miss)
  );

  lcd_irq_status #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(irq_evt),
    .clr_we(wr && hit[WI_CLR]), .clr_bits(pwdata[NUM_IRQ-1:0]),
    .mask_we(wr && hit[WI_MASK]), .mask_bits(pwdata[NUM_IRQ-1:0]),
    .raw(raw), .mask(mask), .masked(masked), .irq(irq)
  );

  lcd_panel_geom #(.DIM_W(DIM_W)) u_geom (
    .clk(clk), .rst_n(rst_n),
    .t0_we(wr && hit[WI_TIM0]), .t0_data(pwdata[7:0]),
    .t1_we(wr && hit[WI_TIM1]), .t1_data(pwdata[9:0]),
    .width(panel_width), .height(panel_height), .resize(resize_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIM; i++) tim[i] <= '0;
      ubase <= '0;
      lbase <= '0;
      ctrl  <= '0;
    end else if (wr) begin
      for (int i = 0; i < NUM_TIM; i++)
        if (hit[i]) tim[i] <= pwdata;
      if (hit[WI_UBASE]) ubase <= pwdata;
      if (hit[WI_LBASE]) lbase <= pwdata;
      if (hit[WI_CTRL])  ctrl  <= pwdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdat = '0;
    for (int i = 0; i < NUM_TIM; i++)
      if (hit[i]) rdat = tim[i];
    if (hit[WI_UBASE] || hit[WI_UCUR]) rdat = ubase;
    if (hit[WI_LBASE] || hit[WI_LCUR]) rdat = lbase;
    if (hit[WI_MASK])  rdat = 32'(mask);
    if (hit[WI_CTRL])  rdat = 32'(ctrl);
    if (hit[WI_RAW])   rdat = 32'(raw);
    if (hit[WI_MSTAT]) rdat = 32'(masked);
    if (id_hit)        rdat = 32'(id_byte(VARIANT, id_idx));
  end

  assign prdata     = rdat;
  assign pslverr    = acc & miss;
  assign disp_en    = ctrl[CB_EN] & ctrl[CB_PWR];
  assign depth_code = ctrl[CB_DEPTH +: 3];
  assign bgr_swap   = ctrl[CB_BGR];
  assign be_bytes   = ctrl[CB_BEB];
  assign be_pixels  = ctrl[CB_BEP];
endmodule

// File: rtl/lcd_regbank_chk.sv
module lcd_regbank_chk #(
  parameter int VARIANT = 0,
  parameter int NUM_IRQ = 4,
  parameter int DIM_W   = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [11:0]        paddr,
  input logic [31:0]        pwdata,
  input logic [31:0]        prdata,
  input logic               pslverr,
  input logic [NUM_IRQ-1:0] irq_evt,
  input logic               irq,
  input logic [DIM_W-1:0]   panel_width,
  input logic [DIM_W-1:0]   panel_height,
  input logic               resize_pulse,
  input logic               disp_en,
  input logic [2:0]         depth_code,
  input logic               bgr_swap,
  input logic               be_bytes,
  input logic               be_pixels
);
  localparam logic [9:0] CTRL_WORD = (VARIANT != 0) ? 10'd6 : 10'd7;
  logic wr;
  assign wr = psel && penable && pwrite;

  p_disp_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == CTRL_WORD) |=> (disp_en == ($past(pwdata[0]) && $past(pwdata[11]))));

  p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == 10'd0) |=>
      (panel_width == DIM_W'((32'($past(pwdata[7:2])) + 32'd1) * 32'd16)));

  p_height_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == 10'd1) |=>
      (panel_height == DIM_W'(32'($past(pwdata[9:0])) + 32'd1)));

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr[11:2] == 10'd10 && (&pwdata[NUM_IRQ-1:0]) && irq_evt == '0) |=> !irq);

  p_err_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == 32'd0));

  p_resize_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    resize_pulse |-> (panel_width != $past(panel_width) || panel_height != $past(panel_height)));

  p_resize_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    resize_pulse |=> !resize_pulse);
endmodule

bind lcd_regbank lcd_regbank_chk #(.VARIANT(VARIANT), .NUM_IRQ(NUM_IRQ), .DIM_W(DIM_W)) u_chk (.*);

// File: tb/lcd_regbank_test.sv
module lcd_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int DW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [NI-1:0] irq_evt = '0;

  logic [31:0] prdata, prdata_x;
  logic pslverr, pslverr_x, irq, irq_x, resize, resize_x;
  logic [DW-1:0] width, height, width_x, height_x;
  logic disp_en, disp_en_x, bgr, bgr_x, beb, beb_x, bep, bep_x;
  logic [2:0] depth, depth_x;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_regbank #(.VARIANT(0), .NUM_IRQ(NI), .DIM_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .irq_evt(irq_evt), .irq(irq), .panel_width(width), .panel_height(height),
    .resize_pulse(resize), .disp_en(disp_en), .depth_code(depth),
    .bgr_swap(bgr), .be_bytes(beb), .be_pixels(bep)
  );

  lcd_regbank #(.VARIANT(1), .NUM_IRQ(NI), .DIM_W(DW)) uut_x (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_x), .pslverr(pslverr_x),
    .irq_evt(irq_evt), .irq(irq_x), .panel_width(width_x), .panel_height(height_x),
    .resize_pulse(resize_x), .disp_en(disp_en_x), .depth_code(depth_x),
    .bgr_swap(bgr_x), .be_bytes(beb_x), .be_pixels(bep_x)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ev(input int word, input logic [31:0] d, input logic [NI-1:0] ev);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
    paddr = 12'(word * 4); pwdata = d;
    @(negedge clk);
    penable = 1'b1; irq_evt = ev;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; irq_evt = '0;
  endtask

  task automatic wr(input int word, input logic [31:0] d);
    wr_ev(word, d, '0);
  endtask

  task automatic rd(input int word, output logic [31:0] d0, output logic [31:0] d1,
                    output logic e0, output logic e1);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'(word * 4);
    @(negedge clk);
    penable = 1'b1;
    #1;
    d0 = prdata; d1 = prdata_x; e0 = pslverr; e1 = pslverr_x;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_ev(input logic [NI-1:0] ev);
    @(negedge clk);
    irq_evt = ev;
    @(negedge clk);
    irq_evt = '0;
  endtask

  function automatic logic [7:0] exp_id(input int variant, input int i);
    logic [7:0] base [8];
    base = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (variant != 0 && i == 0) return 8'h11;
    if (variant != 0 && i == 2) return 8'h24;
    return base[i];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d0, d1, v, c;
    logic e0, e1;
    int pw, ph, nw, nh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R3 reset width", 32'(width), 0);
    check("R4 reset height", 32'(height), 0);
    check("R2 reset disp_en", 32'(disp_en), 0);
    check("R9 reset irq", 32'(irq), 0);
    rd(7, d0, d1, e0, e1);
    check("R1 reset ctrl", d0, 0);

    // R5 storage words and R12 current-address words
    for (int w = 0; w < 6; w++) begin
      v = 32'hA5000000 ^ (32'(w) * 32'h01010101) ^ 32'h0000F00F;
      wr(w, v);
      rd(w, d0, d1, e0, e1);
      check("R5 readback", d0, v);
      check("R5 readback variant1", d1, v);
    end
    rd(11, d0, d1, e0, e1);
    check("R12 upper current", d0, 32'hA5000000 ^ 32'h04040404 ^ 32'h0000F00F);
    rd(12, d0, d1, e0, e1);
    check("R12 lower current", d0, 32'hA5000000 ^ 32'h05050505 ^ 32'h0000F00F);

    // R1 / R2 sweep of control fields (variant 0, word 7)
    for (int k = 0; k < 256; k++) begin
      c = 32'hFFFFF0F0;
      c[0] = k[0]; c[3:1] = k[3:1]; c[8] = k[4]; c[9] = k[5]; c[10] = k[6]; c[11] = k[7];
      wr(7, c);
      check("R2 disp_en", 32'(disp_en), 32'(k[0] & k[7]));
      check("R1 fields", {26'd0, depth, bgr, beb, bep}, {26'd0, 3'(k[3:1]), 1'(k[4]), 1'(k[5]), 1'(k[6])});
      rd(7, d0, d1, e0, e1);
      check("R1 readback", d0, {20'd0, c[11:0]});
    end

    // R6 variant swap: word 6 is mask in base, control in extended
    wr(6, 32'h0000_0F0F);
    rd(6, d0, d1, e0, e1);
    check("R6 base word6 mask", d0, 32'h0000000F);
    check("R6 ext word6 ctrl", d1, 32'h00000F0F);
    check("R6 ext disp_en", 32'(disp_en_x), 1);
    check("R6 ext depth", 32'(depth_x), 7);
    wr(7, 32'h0000_0005);
    rd(7, d0, d1, e0, e1);
    check("R6 base word7 ctrl", d0, 32'h00000005);
    check("R6 ext word7 mask", d1, 32'h00000005);

    // R3 width sweep with R13 pulses
    pw = int'(width);
    for (int k = 0; k < 256; k++) begin
      nw = ((k & 32'hFC) + 4) * 4;
      wr(0, 32'hFFFFFF00 | 32'(k));
      check("R3 width", 32'(width), 32'(nw));
      check("R13 resize on width", 32'(resize), 32'(nw != pw));
      @(negedge clk);
      check("R13 pulse one cycle", 32'(resize), 0);
      pw = nw;
    end

    // R4 height sweep with R13 pulses
    ph = int'(height);
    for (int k = 0; k < 1024; k++) begin
      nh = k + 1;
      wr(1, 32'hFFFFFC00 | 32'(k));
      check("R4 height", 32'(height), 32'(nh));
      check("R13 resize on height", 32'(resize), 32'(nh != ph));
      ph = nh;
    end
    wr(1, 32'h000003FF);
    check("R13 no pulse same height", 32'(resize), 0);

    // R7 / R8 / R9 interrupts
    wr(6, 32'hF);
    wr(10, 32'hF);
    check("R8 clear all", 32'(irq), 0);
    pulse_ev(4'b0101);
    rd(8, d0, d1, e0, e1);
    check("R7 raw status", d0, 32'h5);
    rd(9, d0, d1, e0, e1);
    check("R9 masked full", d0, 32'h5);
    wr(6, 32'h4);
    rd(9, d0, d1, e0, e1);
    check("R9 masked partial", d0, 32'h4);
    check("R9 irq high", 32'(irq), 1);
    wr(10, 32'h4);
    rd(8, d0, d1, e0, e1);
    check("R8 selective clear", d0, 32'h1);
    check("R9 irq low", 32'(irq), 0);
    wr_ev(10, 32'h1, 4'b0001);
    rd(8, d0, d1, e0, e1);
    check("R7 set wins over clear", d0, 32'h1);
    pulse_ev(4'b1000);
    wr(6, 32'h0);
    check("R9 mask off irq", 32'(irq), 0);
    rd(8, d0, d1, e0, e1);
    check("R7 raw independent of mask", d0, 32'h9);

    // R10 ID bytes
    for (int i = 0; i < 8; i++) begin
      rd(1016 + i, d0, d1, e0, e1);
      check("R10 id base", d0, 32'(exp_id(0, i)));
      check("R10 id ext", d1, 32'(exp_id(1, i)));
      check("R10 id no error", 32'(e0), 0);
    end

    // R11 unmapped sweep
    for (int w = 13; w < 1016; w++) begin
      rd(w, d0, d1, e0, e1);
      check("R11 unmapped zero", d0, 0);
      check("R11 unmapped error", 32'(e0), 1);
    end
    wr(7, 32'h00000803);
    wr(300, 32'hFFFFFFFF);
    rd(7, d0, d1, e0, e1);
    check("R11 unmapped write ignored", d0, 32'h00000803);
    check("R11 unmapped write disp_en", 32'(disp_en), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule